// File: doc/BRIEF.md
# Multiply Divide Accumulate Unit

This block is a small arithmetic engine driven through a byte-wide register window. A host picks an operation by writing a control byte. It then writes two 16-bit operands, low byte first. The write of the second operand's high byte launches the operation. Three operations are available: a signed 16x16 multiply, a divide of a signed dividend by an unsigned divisor, and a multiply-accumulate into a 40-bit accumulator. The accumulator wraps modulo 2^40 and keeps an overflow flag that stays set once raised.

The result register holds 40 bits and is shared by all three operations. It is read back through five byte slots. An overflow slot sits beside them. Multiply and multiply-accumulate complete on the launching write. Division runs as a bit-serial restoring divider. While it runs, `busy` is high and the unit ignores every register write.

The divider is a three-state machine:
- DV_IDLE waits for a launch. Launch moves it to DV_RUN.
- DV_RUN performs one quotient bit per cycle. After the last bit, "run complete" moves it to DV_DONE.
- DV_DONE applies the signs and hands the result to the register. "Retire" returns it unconditionally to DV_IDLE.

Top module: `mda_unit`

## Requirements
- R1: After reset, all five result bytes read 0x00, the overflow slot reads 0x00, `busy` is low, and both operands are zero.
- R2: Control register bits [1:0] select the operation: 0 = signed multiply, 1 = divide, 2 or 3 = multiply-accumulate. Writing control with bit 1 set zeroes the 40-bit result/accumulator and the overflow flag. Writing control with bit 1 clear leaves both untouched.
- R3: The register indices are: 0 = control, 1 = operand A low byte, 2 = operand A high byte, 3 = operand B low byte, 4 = operand B high byte. Only a write to index 4 launches an operation. Writes to indices 0 through 3 leave the result unchanged.
- R4: Multiply places signed(A)*signed(B), sign-extended to 40 bits, in the result. It then clears operand B and keeps operand A.
- R5: Divide treats A as signed and B as unsigned. Quotient and remainder truncate toward zero, and the remainder takes the dividend's sign. The result holds the quotient in bits [15:0], the remainder in bits [31:16], and zero in bits [39:32]. `busy` stays high for 17 cycles after the launching edge. Both operands are cleared.
- R6: Divide by a zero divisor gives a result of zero on the launching edge without raising `busy`. It also clears both operands.
- R7: Multiply-accumulate adds signed(A)*signed(B) to the accumulator modulo 2^40. The overflow flag is set whenever the true sum falls outside [0, 2^40), in either direction. The flag stays set until a control write with bit 1 set. Operand B is cleared and operand A is kept.
- R8: Read indices 0 to 4 return result bytes from least to most significant. Index 5 returns 0x80 when overflow is set and 0x00 otherwise. Indices 6 and 7 return 0x00. Reads are combinational from `reg_idx`.
- R9: While `busy` is high, all register writes are ignored. This covers the control and operand registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 3 | Register index for both reads and writes |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_idx` |
| busy | output | 1 | High while a division is in progress |

## Verification
A table walks the multiply and the divide over small positive values, negative one, and the extreme 0x8000 against 0x8000 and 0x7FFF. This separates signed from unsigned products and exposes a missing sign extension into the top byte. The divide cases pair negative dividends with small divisors and with 0xFFFF. These tell truncation toward zero from floor division, and a signed divisor from an unsigned one. They include a zero divisor and the 0x8000 quotient. Directed sequences follow:
- A long run of accumulate steps that crosses 2^40. It confirms the flag rises on exactly the wrapping step and then survives a non-clearing control write.
- Partial operand rewrites that reveal which operand each operation cleared.
- Writes issued during a division, to show they are dropped.

Randomly chosen multiplies and divides are compared against an arithmetic model inside the bench.

// File: rtl/mda_pkg.sv
package mda_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_MAC  = 2'd2,
        OP_MAC2 = 2'd3
    } mda_op_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } div_state_e;

    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_ALO  = 3'd1;
    localparam logic [2:0] IDX_AHI  = 3'd2;
    localparam logic [2:0] IDX_BLO  = 3'd3;
    localparam logic [2:0] IDX_BHI  = 3'd4;
    localparam logic [2:0] IDX_OVF  = 3'd5;

endpackage

// File: rtl/mda_mult.sv
module mda_mult #(
    parameter int OPW = 16
) (
    input  logic signed [OPW-1:0]   a,
    input  logic signed [OPW-1:0]   b,
    output logic signed [2*OPW-1:0] prod
);
    assign prod = a * b;
endmodule

// File: rtl/mda_divider.sv
module mda_divider
    import mda_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] dividend,
    input  logic [OPW-1:0] divisor,
    output logic           busy,
    output logic           done,
    output logic [OPW-1:0] quo_out,
    output logic [OPW-1:0] rem_out
);
    localparam int CNTW = $clog2(OPW);

    div_state_e      state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [OPW-1:0]  quo_q, rem_q, den_q;
    logic            neg_q;
    logic [OPW:0]    shifted, trial;

    assign shifted = {rem_q, quo_q[OPW-1]};
    assign trial   = shifted - {1'b0, den_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, run complete, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE: if (start) state_d = DV_RUN;
            DV_RUN:  if (cnt_q == CNTW'(OPW-1)) state_d = DV_DONE;
            DV_DONE: state_d = DV_IDLE;
            default: state_d = DV_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            neg_q <= 1'b0;
        end else if (state_q == DV_IDLE && start) begin
            neg_q <= dividend[OPW-1];
            quo_q <= dividend[OPW-1] ? (~dividend + 1'b1) : dividend;
            rem_q <= '0;
            den_q <= divisor;
            cnt_q <= '0;
        end else if (state_q == DV_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            if (!trial[OPW]) begin
                rem_q <= trial[OPW-1:0];
                quo_q <= {quo_q[OPW-2:0], 1'b1};
            end else begin
                rem_q <= shifted[OPW-1:0];
                quo_q <= {quo_q[OPW-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != DV_IDLE);
        done    = (state_q == DV_DONE);
        quo_out = neg_q ? (~quo_q + 1'b1) : quo_q;
        rem_out = neg_q ? (~rem_q + 1'b1) : rem_q;
    end

    AST_DIV_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_DONE) |-> ($past(state_q) == DV_RUN)); // R5
    AST_DIV_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_DONE) |-> (rem_q < den_q)); // R5
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == DV_IDLE)); // R9

endmodule

// File: rtl/mda_unit.sv
module mda_unit
    import mda_pkg::*;
#(
    parameter int OPW   = 16,
    parameter int ACCW  = 40,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             busy
);
    localparam int PRODW     = 2 * OPW;
    localparam int RES_BYTES = ACCW / 8;
    localparam int EXTW      = ACCW + 2;

    mda_op_e              op_q;
    logic [OPW-1:0]       opa_q, opb_q, next_b;
    logic [ACCW-1:0]      result_q;
    logic                 ovf_q;
    logic                 wr_ok, launch, div_start, div_done, div_busy;
    logic signed [PRODW-1:0] prod;
    logic [EXTW-1:0]      mac_sum;
    logic                 mac_ovf;
    logic [OPW-1:0]       quo, rem;

    assign wr_ok     = reg_we && !div_busy;
    assign launch    = wr_ok && (reg_idx == IDX_BHI);
    assign next_b    = {reg_wdata, opb_q[7:0]};
    assign div_start = launch && (op_q == OP_DIV) && (next_b != '0);
    assign busy      = div_busy;

    mda_mult #(.OPW(OPW)) u_mult (
        .a    (opa_q),
        .b    (next_b),
        .prod (prod)
    );

    mda_divider #(.OPW(OPW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (opa_q),
        .divisor  (next_b),
        .busy     (div_busy),
        .done     (div_done),
        .quo_out  (quo),
        .rem_out  (rem)
    );

    assign mac_sum = {2'b00, result_q} + {{(EXTW-PRODW){prod[PRODW-1]}}, prod};
    assign mac_ovf = (mac_sum[EXTW-1:ACCW] != 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_MUL;
            opa_q    <= '0;
            opb_q    <= '0;
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (reg_idx)
                    IDX_CTRL: begin
                        op_q <= mda_op_e'(reg_wdata[1:0]);
                        if (reg_wdata[1]) begin
                            result_q <= '0;
                            ovf_q    <= 1'b0;
                        end
                    end
                    IDX_ALO: opa_q[7:0]     <= reg_wdata;
                    IDX_AHI: opa_q[OPW-1:8] <= reg_wdata;
                    IDX_BLO: opb_q[7:0]     <= reg_wdata;
                    IDX_BHI: begin
                        unique case (op_q)
                            OP_MUL: begin
                                result_q <= {{(ACCW-PRODW){prod[PRODW-1]}}, prod};
                                opb_q    <= '0;
                            end
                            OP_DIV: begin
                                opa_q <= '0;
                                opb_q <= '0;
                                if (next_b == '0) result_q <= '0;
                            end
                            default: begin
                                result_q <= mac_sum[ACCW-1:0];
                                if (mac_ovf) ovf_q <= 1'b1;
                                opb_q    <= '0;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
            if (div_done)
                result_q <= {{(ACCW-PRODW){1'b0}}, rem, quo};
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < RES_BYTES; i++)
            if (reg_idx == IDX_W'(i)) reg_rdata = result_q[8*i +: 8];
        if (reg_idx == IDX_OVF) reg_rdata = {ovf_q, 7'b0};
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_ok && reg_idx == IDX_CTRL && reg_wdata[1])) |=> ovf_q); // R7
    AST_OPB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (opb_q == '0)); // R4
    AST_RESULT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !div_done) |=> $stable(result_q)); // R9
    AST_OVF_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_OVF) |-> (reg_rdata == 8'h80 || reg_rdata == 8'h00)); // R8
    AST_DIV_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |=> (result_q[ACCW-1:PRODW] == '0)); // R5

endmodule

// File: tb/mda_unit_bench.sv
module mda_unit_bench;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] a;
        logic [15:0] b;
        logic [39:0] res;
        logic        ovf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h0003, 16'h0005, 40'h000000000F, 1'b0},   // R4 small
        '{8'h00, 16'hFFFF, 16'h0002, 40'hFFFFFFFFFE, 1'b0},   // R4 negative
        '{8'h00, 16'h8000, 16'h8000, 40'h0040000000, 1'b0},   // R4 extreme
        '{8'h00, 16'h8000, 16'h7FFF, 40'hFFC0008000, 1'b0},   // R4 mixed sign
        '{8'h01, 16'd100,  16'd7,    40'h000002000E, 1'b0},   // R5
        '{8'h01, 16'hFF9C, 16'd7,    40'h00FFFEFFF2, 1'b0},   // R5 neg dividend
        '{8'h01, 16'h8000, 16'hFFFF, 40'h0080000000, 1'b0},   // R5 unsigned divisor
        '{8'h01, 16'h7FFF, 16'hFFFF, 40'h007FFF0000, 1'b0},   // R5
        '{8'h01, 16'hFFFF, 16'h0002, 40'h00FFFF0000, 1'b0},   // R5 truncation
        '{8'h01, 16'h8000, 16'h0001, 40'h0000008000, 1'b0},   // R5
        '{8'h01, 16'h1234, 16'h0000, 40'h0000000000, 1'b0},   // R6
        '{8'h02, 16'hFFFF, 16'h0001, 40'hFFFFFFFFFF, 1'b1},   // R7 wrap below zero
        '{8'h03, 16'h0002, 16'h0003, 40'h0000000006, 1'b0},   // R2 R7 clear via op 3
        '{8'h00, 16'h000C, 16'h1000, 40'h000000C000, 1'b0}    // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_idx = 3'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mda_unit u_mda_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] idx, output logic [7:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_res(output logic [39:0] r, output logic ovf);
        logic [7:0] d;
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), d);
            r[8*i +: 8] = d;
        end
        rd(3'd5, d);
        ovf = (d == 8'h80);
    endtask

    task automatic run_op(input logic [7:0] c, input logic [15:0] a, input logic [15:0] b);
        wr(3'd0, c);
        wr(3'd1, a[7:0]);
        wr(3'd2, a[15:8]);
        wr(3'd3, b[7:0]);
        wr(3'd4, b[15:8]);
        wait_idle();
    endtask

    function automatic logic [39:0] model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        longint p;
        int ai, bi, q, r;
        if (op == 2'd0) begin
            p = longint'($signed(a)) * longint'($signed(b));
            return p[39:0];
        end
        if (b == 16'h0) return 40'h0;
        ai = int'($signed(a));
        bi = int'({16'h0, b});
        q = ai / bi;
        r = ai % bi;
        return {8'h00, r[15:0], q[15:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [39:0] r;
        logic        o;
        logic [7:0]  d;
        logic [41:0] acc_m;
        logic        ovf_m;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_res(r, o);
        chk("R1 result", {24'h0, r}, 64'h0);
        chk("R1 ovf", {63'h0, o}, 64'h0);
        chk("R1 busy", {63'h0, busy}, 64'h0);
        wr(3'd4, 8'h00);
        read_res(r, o);
        chk("R1 operands zero", {24'h0, r}, 64'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].ctrl, VECS[v].a, VECS[v].b);
            read_res(r, o);
            chk($sformatf("R4/R5/R6/R7 vector %0d result", v), {24'h0, r}, {24'h0, VECS[v].res});
            chk($sformatf("R7 vector %0d ovf", v), {63'h0, o}, {63'h0, VECS[v].ovf});
        end

        // R8 unused read slots
        rd(3'd7, d);
        chk("R8 idx7 reads zero", {56'h0, d}, 64'h0);
        rd(3'd6, d);
        chk("R8 idx6 reads zero", {56'h0, d}, 64'h0);

        // R3 only B high launches; R4 A kept, B cleared
        run_op(8'h00, 16'd3, 16'd5);
        wr(3'd1, 8'd9);
        wr(3'd3, 8'd9);
        read_res(r, o);
        chk("R3 no launch before B high", {24'h0, r}, 64'd15);
        wr(3'd1, 8'd3);
        wr(3'd3, 8'd0);
        wr(3'd4, 8'h01);
        read_res(r, o);
        chk("R4 A kept B high only", {24'h0, r}, 64'h300);
        wr(3'd4, 8'h00);
        read_res(r, o);
        chk("R4 B cleared after multiply", {24'h0, r}, 64'h0);

        // R5 busy length
        wr(3'd0, 8'h01);
        wr(3'd1, 8'd100);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd7);
        wr(3'd4, 8'd0);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk("R5 busy cycles", 64'(cnt), 64'd17);

        // R5 operands cleared by division
        wr(3'd3, 8'd5);
        wr(3'd4, 8'd0);
        wait_idle();
        read_res(r, o);
        chk("R5 A cleared after divide", {24'h0, r}, 64'h0);

        // R9 writes ignored while busy
        wr(3'd1, 8'd100);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd7);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h02);
        wr(3'd1, 8'hAA);
        wait_idle();
        read_res(r, o);
        chk("R9 result not cleared while busy", {24'h0, r}, 64'h000002000E);
        wr(3'd3, 8'd7);
        wr(3'd4, 8'd0);
        wait_idle();
        read_res(r, o);
        chk("R9 A write ignored while busy", {24'h0, r}, 64'h0);
        wr(3'd1, 8'd100);
        wr(3'd3, 8'd7);
        wr(3'd4, 8'd0);
        wait_idle();
        read_res(r, o);
        chk("R9 op write ignored while busy", {24'h0, r}, 64'h000002000E);

        // R6 zero divisor no busy
        wr(3'd1, 8'd50);
        wr(3'd3, 8'd0);
        wr(3'd4, 8'd0);
        chk("R6 no busy on zero divisor", {63'h0, busy}, 64'h0);
        read_res(r, o);
        chk("R6 zero result", {24'h0, r}, 64'h0);

        // R7 accumulation across 2^40
        wr(3'd0, 8'h02);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h7F);
        acc_m = 42'h0;
        ovf_m = 1'b0;
        for (int k = 0; k < 1100; k++) begin
            wr(3'd3, 8'hFF);
            wr(3'd4, 8'h7F);
            acc_m = acc_m + 42'h3FFF0001;
            if (acc_m[41:40] != 2'b00) ovf_m = 1'b1;
            acc_m[41:40] = 2'b00;
            if (k == 1023) begin
                read_res(r, o);
                chk("R7 no ovf before wrap", {63'h0, o}, 64'h0);
            end
            if (k == 1024) begin
                read_res(r, o);
                chk("R7 ovf on wrap step", {63'h0, o}, 64'h1);
            end
        end
        read_res(r, o);
        chk("R7 accumulator wrapped", {24'h0, r}, {24'h0, acc_m[39:0]});
        chk("R7 ovf model", {63'h0, o}, {63'h0, ovf_m});

        // R2 non-clearing control write keeps acc and flag; R7 sticky
        wr(3'd0, 8'h00);
        read_res(r, o);
        chk("R2 ctrl bit1 clear keeps acc", {24'h0, r}, {24'h0, acc_m[39:0]});
        chk("R7 ovf sticky", {63'h0, o}, 64'h1);
        wr(3'd0, 8'h03);
        read_res(r, o);
        chk("R2 ctrl bit1 clears acc", {24'h0, r}, 64'h0);
        chk("R2 ctrl bit1 clears ovf", {63'h0, o}, 64'h0);

        // random multiplies and divides
        for (int n = 0; n < 40; n++) begin
            logic [1:0]  op;
            logic [15:0] a, b;
            op = 2'($urandom % 2);
            a  = 16'($urandom);
            b  = (n % 8 == 3) ? 16'h0 : 16'($urandom);
            run_op({6'h0, op}, a, b);
            read_res(r, o);
            chk($sformatf("R4/R5 random %0d op%0d", n, op), {24'h0, r}, {24'h0, model(op, a, b)});
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule